// File: doc/BRIEF.md
# Padded Vigenere Stream Encryptor

This block encrypts a stream of letter codes with a repeating keyword and then hides each resulting cipher byte inside a 16-bit word. Letters are coded 0 for a through 25 for z. Each accepted character is shifted by the current keyword letter, modulo 26, in a single pass. The keyword pointer then moves on, returning to the first letter after the last one.

The 8-bit cipher byte is then scattered into a 16-bit word. The positions it lands in come from one of eight fixed interleave masks, and the low three bits of the keyword letter pick the mask. The eight positions that are left over take bits from a free-running pseudo-random register, which blurs the letter statistics of the output stream.

Software writes the keyword into a small store through a write port. It then pulses `start` with the keyword length applied. After that, characters flow in over a valid/ready handshake, and padded words leave one cycle later over a valid/ready handshake.

Top module: `padded_vigenere_enc`

## Requirements
- R1: After reset, and until `start` is pulsed, `out_valid` is 0, `out_word` is 0 and `in_ready` is 0.
- R2: For plaintext code p and key letter k (both 0..25, carried in 8-bit bytes), the cipher byte is (p + k) mod 26.
- R3: Keyword letters are written with `key_we` at `key_addr`. The length (1..16) is taken from `key_len` on `start`. The n-th character accepted after `start` uses key letter n mod length.
- R4: `start` returns the key pointer to 0 and reloads the random register with its seed 16'hACE1.
- R5: The interleave mask is picked by the key letter's bits [2:0]. Masks 0..7 are 7F80, 7BC0, BBA0, 6DB0, D558, 6AAC, AAAA and 5555 (hex), where bit 15 is the first output byte's MSB and a 1 marks a message position.
- R6: Cipher bits fill the mask's 1 positions in order: cipher bit 7 goes to the highest marked bit, and so on down to cipher bit 0 in the lowest marked bit.
- R7: Every position where the mask is 0 carries the same bit of the 16-bit random register. That register shifts left and inserts s[15]^s[13]^s[12]^s[10]. It advances exactly once per accepted character.
- R8: A character accepted on one clock edge appears on `out_word`, with `out_valid` high, right after that edge.
- R9: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and `out_word` stays unchanged. An input presented in that state is not consumed.
- R10: Once an output word is taken and no new character is accepted on that edge, `out_valid` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new stream: latch length, clear key pointer, reseed |
| key_we | input | 1 | Keyword letter write enable |
| key_addr | input | 4 | Keyword letter write address |
| key_char | input | 8 | Keyword letter code 0..25 |
| key_len | input | 5 | Keyword length 1..16, sampled on `start` |
| in_valid | input | 1 | Plaintext code present |
| in_ready | output | 1 | Block can take a plaintext code |
| in_char | input | 8 | Plaintext code 0..25 |
| out_valid | output | 1 | Padded word present |
| out_ready | input | 1 | Consumer takes the padded word |
| out_word | output | 16 | Padded cipher word |

## Verification
The main stream uses a ten-letter key whose low bits cover all eight masks. The plaintext includes 0, 25 and sums of exactly 26 and above, so the modular wrap, every mask and the wrap of the key pointer all show up in the output words. A stall with a changed input held at the port shows whether a held character leaks in: if it did, the next word would be off by one key letter and one random step. A restart with length 1 shows whether the pointer and seed reload, because every word must then use key letter 0 and start from the seed.

// File: rtl/vig_pkg.sv
package vig_pkg;

  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;
  localparam int SEL_W  = 3;

  // Message-position mask per selector; bit 15 is the first byte's MSB.
  function automatic logic [WORD_W-1:0] pad_mask(input logic [SEL_W-1:0] sel);
    logic [WORD_W-1:0] m;
    case (sel)
      3'd0:    m = 16'h7F80;
      3'd1:    m = 16'h7BC0;
      3'd2:    m = 16'hBBA0;
      3'd3:    m = 16'h6DB0;
      3'd4:    m = 16'hD558;
      3'd5:    m = 16'h6AAC;
      3'd6:    m = 16'hAAAA;
      default: m = 16'h5555;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/vig_key_store.sv
module vig_key_store #(
  parameter int KEY_MAX = 16,
  parameter int CHAR_W  = 8,
  localparam int IDX_W  = $clog2(KEY_MAX),
  localparam int LEN_W  = $clog2(KEY_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_addr,
  input  logic [CHAR_W-1:0] wr_data,
  input  logic              restart,
  input  logic [LEN_W-1:0]  len_in,
  input  logic              step,
  output logic [CHAR_W-1:0] cur_key
);

  logic [CHAR_W-1:0] mem [KEY_MAX];
  logic [IDX_W-1:0]  ptr_q;
  logic [LEN_W-1:0]  len_q;
  logic [LEN_W-1:0]  len_eff;

  assign len_eff = (len_in == '0) ? LEN_W'(1) : len_in;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
      len_q <= LEN_W'(1);
    end else if (restart) begin
      ptr_q <= '0;
      len_q <= len_eff;
    end else if (step) begin
      if (LEN_W'(ptr_q) + LEN_W'(1) >= len_q) ptr_q <= '0;
      else                                     ptr_q <= ptr_q + IDX_W'(1);
    end
  end

  assign cur_key = mem[ptr_q];

  // R3
  ptr_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    LEN_W'(ptr_q) < len_q);

  // R4
  restart_ptr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> ptr_q == '0);

endmodule

// File: rtl/vig_lfsr.sv
module vig_lfsr #(
  parameter int          LFSR_W = 16,
  parameter logic [15:0] SEED   = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reseed,
  input  logic              adv,
  output logic [LFSR_W-1:0] state
);

  logic [LFSR_W-1:0] s_q;
  logic              fb;

  assign fb = s_q[15] ^ s_q[13] ^ s_q[12] ^ s_q[10];

  always_ff @(posedge clk) begin
    if (rst || reseed) s_q <= LFSR_W'(SEED);
    else if (adv)      s_q <= {s_q[LFSR_W-2:0], fb};
  end

  assign state = s_q;

  // R7
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    s_q != '0);

  // R7
  lfsr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!adv && !reseed) |=> $stable(s_q));

endmodule

// File: rtl/vig_diffuse.sv
module vig_diffuse
  import vig_pkg::*;
(
  input  logic [BYTE_W-1:0] cipher,
  input  logic [SEL_W-1:0]  sel,
  input  logic [WORD_W-1:0] rnd,
  output logic [WORD_W-1:0] word
);

  logic [WORD_W-1:0] mask;

  assign mask = pad_mask(sel);

  always_comb begin
    int mi;
    mi   = BYTE_W - 1;
    word = '0;
    for (int b = WORD_W - 1; b >= 0; b--) begin
      if (mask[b]) begin
        word[b] = cipher[mi[2:0]];
        mi      = mi - 1;
      end else begin
        word[b] = rnd[b];
      end
    end
  end

endmodule

// File: rtl/padded_vigenere_enc.sv
module padded_vigenere_enc
  import vig_pkg::*;
#(
  parameter int          KEY_MAX = 16,
  parameter int          ALPHA   = 26,
  parameter logic [15:0] SEED    = 16'hACE1,
  localparam int IDX_W = $clog2(KEY_MAX),
  localparam int LEN_W = $clog2(KEY_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              key_we,
  input  logic [IDX_W-1:0]  key_addr,
  input  logic [BYTE_W-1:0] key_char,
  input  logic [LEN_W-1:0]  key_len,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_char,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_word
);

  logic              running_q;
  logic              acc;
  logic [BYTE_W-1:0] cur_key;
  logic [BYTE_W:0]   sum;
  logic [BYTE_W-1:0] cipher;
  logic [WORD_W-1:0] rnd;
  logic [WORD_W-1:0] word_d;

  assign in_ready = running_q && !start && (!out_valid || out_ready);
  assign acc      = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst)        running_q <= 1'b0;
    else if (start) running_q <= 1'b1;
  end

  vig_key_store #(.KEY_MAX(KEY_MAX), .CHAR_W(BYTE_W)) u_keys (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (key_we),
    .wr_addr (key_addr),
    .wr_data (key_char),
    .restart (start),
    .len_in  (key_len),
    .step    (acc),
    .cur_key (cur_key)
  );

  vig_lfsr #(.LFSR_W(WORD_W), .SEED(SEED)) u_rng (
    .clk    (clk),
    .rst    (rst),
    .reseed (start),
    .adv    (acc),
    .state  (rnd)
  );

  assign sum    = {1'b0, in_char} + {1'b0, cur_key};
  assign cipher = (sum >= (BYTE_W+1)'(ALPHA)) ? BYTE_W'(sum - (BYTE_W+1)'(ALPHA))
                                              : BYTE_W'(sum);

  vig_diffuse u_mix (
    .cipher (cipher),
    .sel    (cur_key[SEL_W-1:0]),
    .rnd    (rnd),
    .word   (word_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else if (acc) begin
      out_valid <= 1'b1;
      out_word  <= word_d;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R1
  idle_no_ready_chk: assert property (@(posedge clk) disable iff (rst)
    !running_q |-> !in_ready);

  // R2
  cipher_range_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && in_char < BYTE_W'(ALPHA) && cur_key < BYTE_W'(ALPHA)) |-> cipher < BYTE_W'(ALPHA));

  // R8
  one_cycle_latency_chk: assert property (@(posedge clk) disable iff (rst)
    acc |=> out_valid);

  // R9
  stall_blocks_input_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  // R9
  stall_holds_word_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));

  // R10
  drain_clears_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !acc) |=> !out_valid);

endmodule

// File: tb/sim_padded_vigenere_enc.sv
module sim_padded_vigenere_enc;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        key_we = 1'b0;
  logic [3:0]  key_addr = '0;
  logic [7:0]  key_char = '0;
  logic [4:0]  key_len = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_char = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_word;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  padded_vigenere_enc u0 (
    .clk(clk), .rst(rst), .start(start), .key_we(key_we), .key_addr(key_addr),
    .key_char(key_char), .key_len(key_len), .in_valid(in_valid), .in_ready(in_ready),
    .in_char(in_char), .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word)
  );

  localparam int NKEY = 10;
  localparam logic [7:0] KEYV [NKEY] = '{8'd2, 8'd7, 8'd12, 8'd25, 8'd13,
                                         8'd0, 8'd3, 8'd14, 8'd21, 8'd4};
  localparam int NPT = 16;
  localparam logic [7:0] PTV [NPT] = '{8'd0, 8'd25, 8'd24, 8'd1, 8'd13, 8'd25,
                                       8'd23, 8'd12, 8'd5, 8'd22, 8'd19, 8'd7,
                                       8'd0, 8'd25, 8'd11, 8'd18};

  logic [15:0] m_rng;
  int          m_idx;
  int          m_len;

  function automatic logic [15:0] ref_mask(input logic [2:0] s);
    logic [15:0] r;
    case (s)
      3'd0: r = 16'h7F80; 3'd1: r = 16'h7BC0; 3'd2: r = 16'hBBA0; 3'd3: r = 16'h6DB0;
      3'd4: r = 16'hD558; 3'd5: r = 16'h6AAC; 3'd6: r = 16'hAAAA; default: r = 16'h5555;
    endcase
    return r;
  endfunction

  function automatic logic [15:0] ref_word(input logic [7:0] p, input logic [7:0] k,
                                           input logic [15:0] rn);
    logic [15:0] m;
    logic [15:0] w;
    logic [7:0]  c;
    int          ci;
    c  = 8'((int'(p) + int'(k)) % 26);
    m  = ref_mask(k[2:0]);
    ci = 7;
    for (int b = 15; b >= 0; b--) begin
      if (m[b]) begin w[b] = c[ci]; ci--; end
      else w[b] = rn[b];
    end
    return w;
  endfunction

  function automatic logic [15:0] ref_next(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // Expected word for the next accepted char; advances the model.
  function automatic logic [15:0] model_take(input logic [7:0] p, input logic [7:0] k);
    logic [15:0] w;
    w     = ref_word(p, k, m_rng);
    m_rng = ref_next(m_rng);
    m_idx = (m_idx + 1) % m_len;
    return w;
  endfunction

  task automatic send_one(input logic [7:0] p, input logic [7:0] k, input string req);
    logic [15:0] e;
    @(negedge clk);
    in_char = p; in_valid = 1'b1; out_ready = 1'b1;
    @(posedge clk);
    e = model_take(p, k);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, req, {15'd0, out_valid}, 16'd1);
    chk(out_word == e, req, out_word, e);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 16'd0, 16'd1);
    finish_run();
  end

  initial begin
    logic [15:0] held;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    in_valid = 1'b1;
    @(negedge clk);
    // R1: idle before start even with input offered
    chk(out_valid == 1'b0, "R1", {15'd0, out_valid}, 16'd0);
    chk(out_word == 16'd0, "R1", out_word, 16'd0);
    chk(in_ready == 1'b0, "R1", {15'd0, in_ready}, 16'd0);
    in_valid = 1'b0;

    // R3: load keyword
    for (int i = 0; i < NKEY; i++) begin
      @(negedge clk);
      key_we = 1'b1; key_addr = 4'(i); key_char = KEYV[i];
    end
    @(negedge clk);
    key_we = 1'b0;
    key_len = 5'(NKEY); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    m_rng = 16'hACE1; m_idx = 0; m_len = NKEY;

    // R2 R3 R5 R6 R7 R8: table-driven stream, back-to-back
    for (int i = 0; i < NPT; i++) begin
      logic [15:0] e;
      in_char = PTV[i]; in_valid = 1'b1; out_ready = 1'b1;
      @(posedge clk);
      e = model_take(PTV[i], KEYV[m_idx]);
      @(negedge clk);
      chk(out_valid == 1'b1, "R8", {15'd0, out_valid}, 16'd1);
      chk(out_word == e, "R2/R5/R6/R7", out_word, e);
    end
    in_valid = 1'b0;
    @(negedge clk);
    // R10: drained with no new input
    chk(out_valid == 1'b0, "R10", {15'd0, out_valid}, 16'd0);

    // R9: stall holds word and blocks input
    in_char = 8'd9; in_valid = 1'b1; out_ready = 1'b0;
    @(posedge clk);
    held = model_take(8'd9, KEYV[m_idx]);
    @(negedge clk);
    chk(out_word == held, "R9", out_word, held);
    chk(in_ready == 1'b0, "R9", {15'd0, in_ready}, 16'd0);
    in_char = 8'd17;
    @(negedge clk);
    chk(out_word == held, "R9", out_word, held);
    chk(out_valid == 1'b1, "R9", {15'd0, out_valid}, 16'd1);
    in_valid = 1'b0; out_ready = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R10", {15'd0, out_valid}, 16'd0);
    // R9: held input was not consumed, so the model stays aligned
    send_one(8'd17, KEYV[m_idx], "R9");

    // R4: restart with length 1 reloads pointer and seed
    @(negedge clk);
    key_len = 5'd1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    m_rng = 16'hACE1; m_idx = 0; m_len = 1;
    send_one(8'd3, KEYV[0], "R4");
    send_one(8'd24, KEYV[0], "R3");
    send_one(8'd25, KEYV[0], "R3");

    finish_run();
  end

endmodule